// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block is a memory-mapped controller for 32 general-purpose pins, grouped into four banks of eight. Each bank sits in its own 64-byte window on a simple 32-bit register bus. Every bank has its own registers for:

- pin direction;
- an output latch;
- a synchronized view of the pads;
- raw and masked interrupt status;
- an interrupt mask;
- a per-pin choice between latched-edge and level-following interrupt behaviour.

Software sets and clears mask bits through two separate write addresses, so it never needs a read-modify-write. Interrupt status is cleared by writing ones to it. All masked status bits across the four banks are ORed into one registered interrupt line.

Pad inputs pass through a two-flop synchronizer before any use. Pad outputs and output enables come straight from flops.

Top module: `bgpio_ctrl`

## Requirements
- R1: Pin n maps to bit (n mod 8) of bank (n div 8). Bank b decodes at byte address b*0x40. The in-bank offsets are:
  - 0x00: masked status
  - 0x04: raw status
  - 0x08: mask read / mask-clear write
  - 0x0C: mask-set write
  - 0x10: direction
  - 0x14: output latch
  - 0x18: input
  - 0x20: level select

  bus_rdata returns the addressed register one clock edge after bus_addr is presented. Bits 31:8 read as 0, and offset 0x0C and unmapped offsets read as 0.
- R2: After reset:
  - direction is 0xFF in every bank;
  - output latches are 0;
  - the mask is 0xFF;
  - status is 0;
  - level select is 0;
  - irq_o is 0.
- R3: A direction bit of 1 makes the pin an input (pad_oe bit 0), and 0 makes it an output (pad_oe bit 1). pad_o carries the output latch. Reading the output register returns the latch even while the pin is an input.
- R4: Writing ones at offset 0x0C sets those mask bits. Writing ones at offset 0x08 clears them. Zero bits leave the mask unchanged. Reading 0x08 returns the mask.
- R5: Offset 0x00 reads raw status AND NOT mask.
- R6: After 0xFF is written to a bank's mask-set port, no pad activity in that bank can assert irq_o or any bit at offset 0x00.
- R7: In edge mode (level bit 0), a rising edge of the synchronized level on a pin whose direction is input sets its raw status bit. The bit holds until a write of 1 to that bit at offset 0x04. Pins configured as outputs never set status.
- R8: If a clear write and a new rising edge reach the same status bit in the same cycle, the bit stays set.
- R9: In level mode (level bit 1), the raw status bit follows the synchronized pad level of an input pin. A clear write has no lasting effect while the level is high.
- R10: A pad value is visible at offset 0x18 and to the interrupt logic only after two synchronizer flops. A read presented on the same edge as the pad change still shows the old value.
- R11: irq_o is the registered OR of all masked status bits. It rises one clock edge after a masked status bit becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data (bits 7:0 used) |
| bus_rdata | output | 32 | Registered read data |
| pad_i | input | 32 | Pad input levels |
| pad_o | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables, 1 = drive |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check four things on every cycle:
- the mask-set and mask-clear writes take effect on the next edge;
- an edge-mode status bit never drops without a clear;
- a simultaneous edge beats a clear;
- a fully masked bank never shows masked status, and irq_o always equals the previous cycle's OR of masked status.

Only the bench scenarios can show the rest:
- the address map and pin mapping;
- reset values;
- the exact synchronizer latency seen at the input register;
- level-mode behaviour after a clear;
- the cycle on which irq_o first rises after a pad edge.

// File: rtl/bgpio_pkg.sv
package bgpio_pkg;
  localparam int BANKS_DEF  = 4;
  localparam int BANK_W_DEF = 8;
  localparam int WIN_BITS   = 6; // 64-byte window per bank

  localparam logic [WIN_BITS-1:0] OFF_MSTAT = 6'h00;
  localparam logic [WIN_BITS-1:0] OFF_RAW   = 6'h04;
  localparam logic [WIN_BITS-1:0] OFF_MCLR  = 6'h08;
  localparam logic [WIN_BITS-1:0] OFF_MSET  = 6'h0C;
  localparam logic [WIN_BITS-1:0] OFF_DIR   = 6'h10;
  localparam logic [WIN_BITS-1:0] OFF_OUT   = 6'h14;
  localparam logic [WIN_BITS-1:0] OFF_IN    = 6'h18;
  localparam logic [WIN_BITS-1:0] OFF_LVL   = 6'h20;
endpackage

// File: rtl/bgpio_sync.sv
module bgpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/bgpio_bank.sv
module bgpio_bank
  import bgpio_pkg::*;
#(
  parameter int W = BANK_W_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we_i,
  input  logic [WIN_BITS-1:0] off_i,
  input  logic [W-1:0]        wdata_i,
  input  logic [WIN_BITS-1:0] roff_i,
  output logic [W-1:0]        rdata_o,
  input  logic [W-1:0]        pad_i,
  output logic [W-1:0]        pad_o,
  output logic [W-1:0]        pad_oe,
  output logic [W-1:0]        masked_o
);
  logic [W-1:0] dir_q, out_q, mask_q, stat_q, lvl_q, prev_q;
  logic [W-1:0] sync_lv, rise, clr, stat_n;

  bgpio_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d_i(pad_i), .q_o(sync_lv)
  );

  assign rise   = sync_lv & ~prev_q & dir_q;
  assign clr    = (we_i && off_i == OFF_RAW) ? wdata_i : '0;
  assign stat_n = (lvl_q & sync_lv & dir_q)
                | (~lvl_q & ((stat_q & ~clr) | rise));

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '1;
      out_q  <= '0;
      mask_q <= '1;
      stat_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= sync_lv;
      stat_q <= stat_n;
      if (we_i) begin
        case (off_i)
          OFF_DIR:  dir_q  <= wdata_i;
          OFF_OUT:  out_q  <= wdata_i;
          OFF_LVL:  lvl_q  <= wdata_i;
          OFF_MSET: mask_q <= mask_q | wdata_i;
          OFF_MCLR: mask_q <= mask_q & ~wdata_i;
          default:  ;
        endcase
      end
    end
  end

  assign masked_o = stat_q & ~mask_q;
  assign pad_o    = out_q;
  assign pad_oe   = ~dir_q;

  always_comb begin
    case (roff_i)
      OFF_MSTAT: rdata_o = masked_o;
      OFF_RAW:   rdata_o = stat_q;
      OFF_MCLR:  rdata_o = mask_q;
      OFF_DIR:   rdata_o = dir_q;
      OFF_OUT:   rdata_o = out_q;
      OFF_IN:    rdata_o = sync_lv;
      OFF_LVL:   rdata_o = lvl_q;
      default:   rdata_o = '0;
    endcase
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    (we_i && off_i == OFF_MSET) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i))); // R4
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
    (we_i && off_i == OFF_MCLR) |=> ((mask_q & $past(wdata_i)) == '0)); // R4
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(stat_q & ~lvl_q & ~clr)) == $past(stat_q & ~lvl_q & ~clr))); // R7
  AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & $past(rise & ~lvl_q)) == $past(rise & ~lvl_q))); // R8
  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (&mask_q) |-> (masked_o == '0)); // R6
endmodule

// File: rtl/bgpio_ctrl.sv
module bgpio_ctrl
  import bgpio_pkg::*;
#(
  parameter int NBANKS = BANKS_DEF,
  parameter int BANK_W = BANK_W_DEF,
  parameter int BUS_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [WIN_BITS+$clog2(NBANKS)-1:0] bus_addr,
  input  logic                       bus_we,
  input  logic [BUS_W-1:0]           bus_wdata,
  output logic [BUS_W-1:0]           bus_rdata,
  input  logic [NBANKS*BANK_W-1:0]   pad_i,
  output logic [NBANKS*BANK_W-1:0]   pad_o,
  output logic [NBANKS*BANK_W-1:0]   pad_oe,
  output logic                       irq_o
);
  localparam int SEL_W  = $clog2(NBANKS);
  localparam int ADDR_W = WIN_BITS + SEL_W;
  localparam int PINS   = NBANKS * BANK_W;

  logic [SEL_W-1:0]    sel;
  logic [WIN_BITS-1:0] off;
  logic [BANK_W-1:0]   bank_rd [NBANKS];
  logic [PINS-1:0]     masked_all;

  assign sel = bus_addr[ADDR_W-1:WIN_BITS];
  assign off = bus_addr[WIN_BITS-1:0];

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    bgpio_bank #(.W(BANK_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .we_i     (bus_we && sel == SEL_W'(b)),
      .off_i    (off),
      .wdata_i  (bus_wdata[BANK_W-1:0]),
      .roff_i   (off),
      .rdata_o  (bank_rd[b]),
      .pad_i    (pad_i[b*BANK_W +: BANK_W]),
      .pad_o    (pad_o[b*BANK_W +: BANK_W]),
      .pad_oe   (pad_oe[b*BANK_W +: BANK_W]),
      .masked_o (masked_all[b*BANK_W +: BANK_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
    end else begin
      bus_rdata <= BUS_W'(bank_rd[sel]);
      irq_o     <= |masked_all;
    end
  end

  AST_IRQ_REGISTERED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|masked_all))); // R11
endmodule

// File: tb/bgpio_ctrl_tb_top.sv
module bgpio_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_i = '0;
  logic [31:0] pad_o, pad_oe;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk; // 50 MHz

  bgpio_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .irq_o(irq_o)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v === exp, req, v, exp);
  endtask

  task automatic t_reset();
    rd_chk(8'h10, 32'hFF, "R2 dir");
    rd_chk(8'hC8, 32'hFF, "R2 mask");
    rd_chk(8'h54, 32'h00, "R2 out");
    rd_chk(8'h84, 32'h00, "R2 raw");
    rd_chk(8'hE0, 32'h00, "R2 lvl");
    check(pad_oe === 32'h0, "R2 oe", pad_oe, 32'h0);
    check(irq_o === 1'b0, "R2 irq", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_dir_out();
    wr(8'h50, 32'h0F);
    wr(8'h54, 32'hA5);
    @(negedge clk);
    check(pad_oe[15:8] === 8'hF0, "R3 oe", {24'b0, pad_oe[15:8]}, 32'hF0);
    check(pad_o[15:8] === 8'hA5, "R3 pad_o", {24'b0, pad_o[15:8]}, 32'hA5);
    wr(8'h50, 32'hFF);
    rd_chk(8'h54, 32'hA5, "R3 latch readback as input");
    rd_chk(8'h5C, 32'h00, "R1 unmapped offset");
    rd_chk(8'h4C, 32'h00, "R1 mask-set port reads 0");
  endtask

  task automatic t_sync();
    logic [31:0] v;
    @(negedge clk);
    bus_addr = 8'hD8;
    pad_i[31:24] = 8'h3C;
    @(negedge clk); v = bus_rdata;
    check(v === 32'h00, "R10 after 1 edge", v, 32'h00);
    @(negedge clk); v = bus_rdata;
    check(v === 32'h00, "R10 after 2 edges (reg read)", v, 32'h00);
    @(negedge clk); v = bus_rdata;
    check(v === 32'h3C, "R10 after 3 edges", v, 32'h3C);
    pad_i[31:24] = 8'h00;
    repeat (4) @(negedge clk);
    wr(8'hC4, 32'hFF);
  endtask

  task automatic t_mapping_edge();
    pad_i[10] = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk(8'h44, 32'h04, "R1 pin10 -> bank1 bit2");
    pad_i[10] = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk(8'h44, 32'h04, "R7 sticky after level drop");
    rd_chk(8'h40, 32'h00, "R5 masked while mask set");
    wr(8'h44, 32'h01);
    rd_chk(8'h44, 32'h04, "R7 clear of other bit no effect");
    wr(8'h44, 32'h04);
    rd_chk(8'h44, 32'h00, "R7 write-one clears");
  endtask

  task automatic t_mask_irq();
    wr(8'h08, 32'h06);
    rd_chk(8'h08, 32'hF9, "R4 mask clear");
    wr(8'h0C, 32'h02);
    rd_chk(8'h08, 32'hFB, "R4 mask set");
    @(negedge clk);
    pad_i[2] = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check(irq_o === 1'b0, "R11 irq not before register", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    check(irq_o === 1'b1, "R11 irq one edge after status", {31'b0, irq_o}, 32'h1);
    rd_chk(8'h00, 32'h04, "R5 masked status");
    pad_i[2] = 1'b0;
    pad_i[1] = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk(8'h04, 32'h06, "R5 raw shows masked pin");
    rd_chk(8'h00, 32'h04, "R5 masked pin hidden");
    pad_i[1] = 1'b0;
    wr(8'h04, 32'hFF);
    repeat (2) @(negedge clk);
    check(irq_o === 1'b0, "R11 irq drops after clear", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_edge_wins();
    logic [31:0] v;
    pad_i[3] = 1'b1;
    repeat (4) @(negedge clk);
    pad_i[3] = 1'b0;
    repeat (4) @(negedge clk);
    pad_i[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    bus_addr = 8'h04; bus_we = 1'b1; bus_wdata = 32'h08;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
    @(negedge clk); v = bus_rdata;
    check(v === 32'h08, "R8 edge beats clear", v, 32'h08);
    pad_i[3] = 1'b0;
    repeat (3) @(negedge clk);
    wr(8'h04, 32'h08);
    rd_chk(8'h04, 32'h00, "R8 later clear works");
  endtask

  task automatic t_out_pin_no_status();
    wr(8'h10, 32'hDF);
    pad_i[5] = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk(8'h04, 32'h00, "R7 output pin sets no status");
    pad_i[5] = 1'b0;
    repeat (3) @(negedge clk);
    wr(8'h10, 32'hFF);
  endtask

  task automatic t_level();
    wr(8'h20, 32'h01);
    wr(8'h08, 32'h01);
    pad_i[0] = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk(8'h04, 32'h01, "R9 level high");
    wr(8'h04, 32'h01);
    rd_chk(8'h04, 32'h01, "R9 clear no lasting effect");
    check(irq_o === 1'b1, "R9 level irq", {31'b0, irq_o}, 32'h1);
    pad_i[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk(8'h04, 32'h00, "R9 follows level low");
    check(irq_o === 1'b0, "R9 irq low", {31'b0, irq_o}, 32'h0);
    wr(8'h20, 32'h00);
  endtask

  task automatic t_full_mask();
    bit seen = 1'b0;
    wr(8'h88, 32'hFF);
    wr(8'h8C, 32'hFF);
    rd_chk(8'h88, 32'hFF, "R6 bank2 mask all");
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      pad_i[23:16] = 8'(k * 37);
      if (irq_o !== 1'b0) seen = 1'b1;
    end
    repeat (4) @(negedge clk);
    check(seen == 1'b0, "R6 no irq from masked bank", {31'b0, seen}, 32'h0);
    rd_chk(8'h80, 32'h00, "R6 no masked status");
    pad_i[23:16] = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_dir_out();
    t_sync();
    t_mapping_edge();
    t_mask_irq();
    t_edge_wins();
    t_out_pin_no_status();
    t_level();
    t_full_mask();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule